// File: doc/BRIEF.md
# SPI Register Slave with Selectable Status Byte

This block is the register-access front end of a peripheral that sits on an SPI bus. It acts as an SPI mode-0 slave (clock idle low, data captured on the rising clock edge and launched on the falling edge, most significant bit first). A transaction opens with a command byte, followed by one data byte that is either returned (read) or stored (write). While the master is still clocking in the command byte, the slave is already returning a status byte on MISO. A two-bit selector inside the block's 8-bit control register chooses what that status byte is: a constant zero, the transceiver-state input, the link-level input or the interrupt-flag input.

All SPI pins are brought into the system clock domain through a synchronizer, and the block reacts to the edges it detects there. The selected status value is captured at the cycle in which the falling chip select is seen, so its top bit is on MISO well before the first rising SCLK edge. The whole control register is presented on an output so its other bits can steer the surrounding logic.

Top module: `spi_status_slave`

## Requirements
- R1: In every transaction the first byte on MISO, returned while the command byte is received, is the selected status value captured when chip select falls, sent MSB first.
- R2: The selector is control register bits [3:2]: 0 returns 0x00, 1 returns trx_state, 2 returns link_level, 3 returns irq_flags.
- R3: After reset the control register holds 0x20 (only bit 5 set), so the first MISO byte is 0x00.
- R4: In the command byte, bit 7 = 1 means write and bit 7 = 0 means read, bits [5:0] are the register address and bit 6 has no effect.
- R5: A read of address 0x04 returns the control register in the second MISO byte.
- R6: A write to address 0x04 stores all eight bits of the second byte, which then appear on ctrl_o and read back unchanged.
- R7: Every address other than 0x04 reads as 0x00 and ignores writes.
- R8: Raising chip select before a byte is complete discards the partial byte; nothing is written and the next transaction starts with a fresh command byte.
- R9: MOSI is taken on rising SCLK edges and MISO changes on falling edges; bytes after the second one return 0x00 and are not stored.
- R10: MISO is held at 0 while chip select is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sclk | input | 1 | SPI serial clock from the master |
| cs_n | input | 1 | SPI chip select, active low |
| mosi | input | 1 | Serial data from the master |
| miso | output | 1 | Serial data to the master |
| trx_state | input | 8 | Transceiver-state status source (selector 1) |
| link_level | input | 8 | Link-level status source (selector 2) |
| irq_flags | input | 8 | Interrupt-flag status source (selector 3) |
| ctrl_o | output | 8 | Current control register contents |

## Verification
Each SPI pin reaches the logic after two synchronizer stages and one edge-detect stage, so a MISO change is due three to four system clocks after the SCLK or chip-select edge that causes it, and a register write lands within five clocks of the sixteenth rising SCLK edge. The bench holds every SCLK level for eight system clocks and samples MISO just before raising SCLK, and reads ctrl_o only after chip select has been high for many cycles, so each sample falls well after its result is due. The selector is swept over all four codes with eight status patterns each, and the expected first byte is worked out in the bench from the code just written.

// File: rtl/spi_stat_pkg.sv
package spi_stat_pkg;

    localparam int BYTE_W  = 8;
    localparam int ADDR_W  = 6;
    localparam int SEL_LSB = 2;
    localparam int SEL_W   = 2;

    typedef enum logic [SEL_W-1:0] {
        SEL_ZERO  = 2'd0,
        SEL_TRX   = 2'd1,
        SEL_LEVEL = 2'd2,
        SEL_IRQ   = 2'd3
    } stat_sel_e;

    typedef enum logic [1:0] {
        PH_CMD  = 2'd0,
        PH_DATA = 2'd1,
        PH_TAIL = 2'd2
    } phase_e;

    typedef struct packed {
        logic              wr;
        logic              spare;
        logic [ADDR_W-1:0] addr;
    } cmd_t;

    function automatic cmd_t decode_cmd(input logic [BYTE_W-1:0] b);
        return cmd_t'(b);
    endfunction

    function automatic stat_sel_e sel_of(input logic [BYTE_W-1:0] ctrl);
        return stat_sel_e'(ctrl[SEL_LSB +: SEL_W]);
    endfunction

endpackage

// File: rtl/spi_pin_sync.sv
module spi_pin_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic sclk,
    input  logic cs_n,
    input  logic mosi,
    output logic sclk_rise,
    output logic sclk_fall,
    output logic cs_fall,
    output logic cs_rise,
    output logic cs_low,
    output logic cs_act,
    output logic mosi_s
);
    localparam int LAST = STAGES - 1;

    logic [STAGES-1:0] s_sclk;
    logic [STAGES-1:0] s_cs;
    logic [STAGES-1:0] s_mosi;
    logic              sclk_d;
    logic              cs_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            s_sclk <= '0;
            s_cs   <= '1;
            s_mosi <= '0;
            sclk_d <= 1'b0;
            cs_d   <= 1'b1;
            cs_act <= 1'b0;
        end else begin
            s_sclk <= {s_sclk[STAGES-2:0], sclk};
            s_cs   <= {s_cs[STAGES-2:0], cs_n};
            s_mosi <= {s_mosi[STAGES-2:0], mosi};
            sclk_d <= s_sclk[LAST];
            cs_d   <= s_cs[LAST];
            cs_act <= ~s_cs[LAST];
        end
    end

    assign cs_low    = ~s_cs[LAST];
    assign sclk_rise = cs_low & s_sclk[LAST] & ~sclk_d;
    assign sclk_fall = cs_low & ~s_sclk[LAST] & sclk_d;
    assign cs_fall   = cs_d & ~s_cs[LAST];
    assign cs_rise   = ~cs_d & s_cs[LAST];
    assign mosi_s    = s_mosi[LAST];

endmodule

// File: rtl/spi_status_sel.sv
module spi_status_sel
    import spi_stat_pkg::*;
(
    input  stat_sel_e         sel,
    input  logic [BYTE_W-1:0] src_trx,
    input  logic [BYTE_W-1:0] src_level,
    input  logic [BYTE_W-1:0] src_irq,
    output logic [BYTE_W-1:0] status
);
    always_comb begin
        unique case (sel)
            SEL_TRX:   status = src_trx;
            SEL_LEVEL: status = src_level;
            SEL_IRQ:   status = src_irq;
            default:   status = '0;
        endcase
    end
endmodule

// File: rtl/spi_shifter.sv
module spi_shifter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         cs_fall,
    input  logic         cs_rise,
    input  logic         cs_act,
    input  logic         sclk_rise,
    input  logic         sclk_fall,
    input  logic         mosi_s,
    input  logic [W-1:0] first_byte,
    input  logic         load_req,
    input  logic [W-1:0] next_byte,
    output logic         miso,
    output logic [W-1:0] rx_byte,
    output logic         byte_done,
    output logic [W-1:0] tx_q,
    output logic [$clog2(W)-1:0] bit_idx
);
    localparam int CNT_W = $clog2(W);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(W - 1);

    logic [W-2:0] rx_sh;
    logic [W-1:0] nxt_q;
    logic         pend_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            rx_sh     <= '0;
            rx_byte   <= '0;
            byte_done <= 1'b0;
            tx_q      <= '0;
            nxt_q     <= '0;
            pend_q    <= 1'b0;
            bit_idx   <= '0;
        end else begin
            byte_done <= 1'b0;
            if (cs_fall) begin
                tx_q    <= first_byte;
                pend_q  <= 1'b0;
                bit_idx <= '0;
            end else if (cs_rise) begin
                pend_q  <= 1'b0;
                bit_idx <= '0;
            end else begin
                if (sclk_rise) begin
                    rx_sh <= {rx_sh[W-3:0], mosi_s};
                    if (bit_idx == LAST_BIT) begin
                        rx_byte   <= {rx_sh, mosi_s};
                        byte_done <= 1'b1;
                        bit_idx   <= '0;
                    end else begin
                        bit_idx <= bit_idx + 1'b1;
                    end
                end
                if (load_req) begin
                    nxt_q  <= next_byte;
                    pend_q <= 1'b1;
                end else if (sclk_fall) begin
                    if (pend_q) begin
                        tx_q   <= nxt_q;
                        pend_q <= 1'b0;
                    end else begin
                        tx_q <= {tx_q[W-2:0], 1'b0};
                    end
                end
            end
        end
    end

    assign miso = cs_act & tx_q[W-1];

endmodule

// File: rtl/spi_reg_ctrl.sv
module spi_reg_ctrl
    import spi_stat_pkg::*;
#(
    parameter logic [ADDR_W-1:0] CTRL_ADDR  = 6'h04,
    parameter logic [BYTE_W-1:0] CTRL_RESET = 8'h20
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cs_fall,
    input  logic              byte_done,
    input  logic [BYTE_W-1:0] rx_byte,
    output logic              load_req,
    output logic [BYTE_W-1:0] next_byte,
    output logic              wr_strobe,
    output logic [BYTE_W-1:0] ctrl_q
);
    phase_e            phase_q;
    logic              cmd_wr_q;
    logic [ADDR_W-1:0] cmd_addr_q;
    cmd_t              cmd_now;

    function automatic logic [BYTE_W-1:0] read_reg(
        input logic [ADDR_W-1:0] a,
        input logic [BYTE_W-1:0] ctrl
    );
        return (a == CTRL_ADDR) ? ctrl : '0;
    endfunction

    assign cmd_now   = decode_cmd(rx_byte);
    assign load_req  = byte_done && (phase_q == PH_CMD) && !cmd_now.wr;
    assign next_byte = read_reg(cmd_now.addr, ctrl_q);
    assign wr_strobe = byte_done && (phase_q == PH_DATA) && cmd_wr_q
                       && (cmd_addr_q == CTRL_ADDR);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q    <= PH_CMD;
            cmd_wr_q   <= 1'b0;
            cmd_addr_q <= '0;
            ctrl_q     <= CTRL_RESET;
        end else if (cs_fall) begin
            phase_q <= PH_CMD;
        end else if (byte_done) begin
            unique case (phase_q)
                PH_CMD: begin
                    cmd_wr_q   <= cmd_now.wr;
                    cmd_addr_q <= cmd_now.addr;
                    phase_q    <= PH_DATA;
                end
                PH_DATA: begin
                    if (wr_strobe) ctrl_q <= rx_byte;
                    phase_q <= PH_TAIL;
                end
                default: phase_q <= PH_TAIL;
            endcase
        end
    end

endmodule

// File: rtl/spi_status_slave.sv
module spi_status_slave
    import spi_stat_pkg::*;
#(
    parameter int                SYNC_STAGES = 2,
    parameter logic [ADDR_W-1:0] CTRL_ADDR   = 6'h04,
    parameter logic [BYTE_W-1:0] CTRL_RESET  = 8'h20
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sclk,
    input  logic              cs_n,
    input  logic              mosi,
    output logic              miso,
    input  logic [BYTE_W-1:0] trx_state,
    input  logic [BYTE_W-1:0] link_level,
    input  logic [BYTE_W-1:0] irq_flags,
    output logic [BYTE_W-1:0] ctrl_o
);
    localparam int CNT_W = $clog2(BYTE_W);

    logic              sclk_rise, sclk_fall, cs_fall, cs_rise, cs_low, cs_act, mosi_s;
    logic [BYTE_W-1:0] status_byte;
    logic [BYTE_W-1:0] rx_byte, next_byte, tx_q, ctrl_q;
    logic              byte_done, load_req, wr_strobe;
    logic [CNT_W-1:0]  bit_idx;
    logic              cs_low_unused;

    assign cs_low_unused = cs_low;

    spi_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .sclk(sclk), .cs_n(cs_n), .mosi(mosi),
        .sclk_rise(sclk_rise), .sclk_fall(sclk_fall), .cs_fall(cs_fall),
        .cs_rise(cs_rise), .cs_low(cs_low), .cs_act(cs_act), .mosi_s(mosi_s)
    );

    spi_status_sel u_sel (
        .sel(sel_of(ctrl_q)), .src_trx(trx_state), .src_level(link_level),
        .src_irq(irq_flags), .status(status_byte)
    );

    spi_shifter #(.W(BYTE_W)) u_shift (
        .clk(clk), .rst(rst), .cs_fall(cs_fall), .cs_rise(cs_rise),
        .cs_act(cs_act), .sclk_rise(sclk_rise), .sclk_fall(sclk_fall),
        .mosi_s(mosi_s), .first_byte(status_byte), .load_req(load_req),
        .next_byte(next_byte), .miso(miso), .rx_byte(rx_byte),
        .byte_done(byte_done), .tx_q(tx_q), .bit_idx(bit_idx)
    );

    spi_reg_ctrl #(.CTRL_ADDR(CTRL_ADDR), .CTRL_RESET(CTRL_RESET)) u_regs (
        .clk(clk), .rst(rst), .cs_fall(cs_fall), .byte_done(byte_done),
        .rx_byte(rx_byte), .load_req(load_req), .next_byte(next_byte),
        .wr_strobe(wr_strobe), .ctrl_q(ctrl_q)
    );

    assign ctrl_o = ctrl_q;

endmodule

// File: rtl/spi_status_slave_chk.sv
module spi_status_slave_chk
    import spi_stat_pkg::*;
#(
    parameter logic [BYTE_W-1:0] CTRL_RESET = 8'h20
) (
    input logic              clk,
    input logic              rst,
    input logic              cs_fall,
    input logic              cs_rise,
    input logic              wr_strobe,
    input logic [BYTE_W-1:0] tx_q,
    input logic [BYTE_W-1:0] ctrl_o,
    input logic [$clog2(BYTE_W)-1:0] bit_idx,
    input logic [BYTE_W-1:0] trx_state,
    input logic [BYTE_W-1:0] link_level,
    input logic [BYTE_W-1:0] irq_flags
);
    logic [BYTE_W-1:0] want_stat;

    always_comb begin
        case (ctrl_o[SEL_LSB +: SEL_W])
            2'd1:    want_stat = trx_state;
            2'd2:    want_stat = link_level;
            2'd3:    want_stat = irq_flags;
            default: want_stat = '0;
        endcase
    end

    AST_FIRST_BYTE_LOAD: assert property (@(posedge clk) disable iff (rst)
        cs_fall |=> tx_q == $past(want_stat)); // R1

    AST_ZERO_SELECT: assert property (@(posedge clk) disable iff (rst)
        (cs_fall && ctrl_o[SEL_LSB +: SEL_W] == 2'd0) |=> tx_q == '0); // R2

    AST_CTRL_RESET: assert property (@(posedge clk)
        rst |=> ctrl_o == CTRL_RESET); // R3

    AST_CTRL_WRITE_PATH: assert property (@(posedge clk) disable iff (rst)
        !$stable(ctrl_o) |-> $past(wr_strobe)); // R6

    AST_BIT_CLEAR: assert property (@(posedge clk) disable iff (rst)
        cs_rise |=> bit_idx == '0); // R8

endmodule

bind spi_status_slave spi_status_slave_chk #(.CTRL_RESET(CTRL_RESET)) u_chk (
    .clk(clk), .rst(rst), .cs_fall(cs_fall), .cs_rise(cs_rise),
    .wr_strobe(wr_strobe), .tx_q(tx_q), .ctrl_o(ctrl_o), .bit_idx(bit_idx),
    .trx_state(trx_state), .link_level(link_level), .irq_flags(irq_flags)
);

// File: tb/spi_status_slave_tb.sv
module spi_status_slave_tb;
    localparam int CLK_PERIOD = 10;
    localparam int HALF       = 8 * CLK_PERIOD;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       sclk = 1'b0;
    logic       cs_n = 1'b1;
    logic       mosi = 1'b0;
    logic       miso;
    logic [7:0] trx_state = 8'h00;
    logic [7:0] link_level = 8'h00;
    logic [7:0] irq_flags = 8'h00;
    logic [7:0] ctrl_o;

    int n_checks = 0;
    int n_fail   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    spi_status_slave u_dut (
        .clk(clk), .rst(rst), .sclk(sclk), .cs_n(cs_n), .mosi(mosi),
        .miso(miso), .trx_state(trx_state), .link_level(link_level),
        .irq_flags(irq_flags), .ctrl_o(ctrl_o)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic spi_txn(input logic [23:0] tx, input int nbits, output logic [23:0] rx);
        rx = '0;
        @(negedge clk);
        cs_n = 1'b0;
        #(HALF);
        for (int i = 0; i < nbits; i++) begin
            mosi = tx[23-i];
            #(HALF);
            rx[23-i] = miso;
            sclk = 1'b1;
            #(HALF);
            sclk = 1'b0;
        end
        #(HALF);
        cs_n = 1'b1;
        mosi = 1'b0;
        #(4*HALF);
        check("R10 idle miso", {7'd0, miso}, 8'h00);
    endtask

    function automatic logic [7:0] want_first(input logic [1:0] m);
        case (m)
            2'd1:    return trx_state;
            2'd2:    return link_level;
            2'd3:    return irq_flags;
            default: return 8'h00;
        endcase
    endfunction

    initial begin
        #(CLK_PERIOD * 150000);
        n_fail++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        logic [23:0] rx;
        logic [7:0]  val;
        trx_state  = 8'h5A;
        link_level = 8'hC3;
        irq_flags  = 8'h81;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        repeat (3) @(negedge clk);

        // R3 reset value, R10 idle line
        check("R3 ctrl after reset", ctrl_o, 8'h20);
        check("R10 miso after reset", {7'd0, miso}, 8'h00);
        // R3 first byte zero, R5 read of control register
        spi_txn({8'h04, 8'h00, 8'h00}, 16, rx);
        check("R3 first byte after reset", rx[23:16], 8'h00);
        check("R5 read ctrl", rx[15:8], 8'h20);

        // R1 R2 sweep all selector codes with several status patterns
        for (int m = 0; m < 4; m++) begin
            val = 8'h20 | 8'(m << 2) | 8'(m);
            spi_txn({8'h84, val, 8'h00}, 16, rx);
            check("R6 ctrl_o after write", ctrl_o, val);
            for (int p = 0; p < 8; p++) begin
                trx_state  = 8'(p * 37 + 1);
                link_level = 8'(p * 53 + 7);
                irq_flags  = 8'(p * 91 + 3);
                spi_txn({8'h04, 8'h00, 8'h00}, 16, rx);
                check("R1 R2 first byte by selector", rx[23:16], want_first(2'(m)));
                check("R5 read ctrl in sweep", rx[15:8], val);
            end
        end

        // R6 every bit writable
        spi_txn({8'h84, 8'hFF, 8'h00}, 16, rx);
        check("R6 all ones stored", ctrl_o, 8'hFF);
        spi_txn({8'h04, 8'h00, 8'h00}, 16, rx);
        check("R1 first byte select 3", rx[23:16], irq_flags);
        check("R6 all ones read", rx[15:8], 8'hFF);
        spi_txn({8'h84, 8'h00, 8'h00}, 16, rx);
        check("R6 all zeros stored", ctrl_o, 8'h00);
        spi_txn({8'h04, 8'h00, 8'h00}, 16, rx);
        check("R6 all zeros read", rx[15:8], 8'h00);
        check("R2 select 0 gives zero", rx[23:16], 8'h00);

        // R7 other addresses
        spi_txn({8'h84, 8'h2A, 8'h00}, 16, rx);
        spi_txn({8'h85, 8'hAA, 8'h00}, 16, rx);
        check("R7 write elsewhere ignored", ctrl_o, 8'h2A);
        spi_txn({8'h05, 8'h00, 8'h00}, 16, rx);
        check("R7 read addr 05", rx[15:8], 8'h00);
        spi_txn({8'h3F, 8'h00, 8'h00}, 16, rx);
        check("R7 read addr 3F", rx[15:8], 8'h00);
        check("R1 first byte select 2", rx[23:16], link_level);

        // R4 bit 6 of command has no effect
        spi_txn({8'h44, 8'h00, 8'h00}, 16, rx);
        check("R4 read with bit6 set", rx[15:8], 8'h2A);
        spi_txn({8'hC4, 8'h0C, 8'h00}, 16, rx);
        check("R4 write with bit6 set", ctrl_o, 8'h0C);

        // R8 partial data byte is dropped
        spi_txn({8'h84, 8'hF0, 8'h00}, 12, rx);
        check("R8 partial write dropped", ctrl_o, 8'h0C);
        spi_txn({8'h04, 8'h00, 8'h00}, 5, rx);
        spi_txn({8'h04, 8'h00, 8'h00}, 16, rx);
        check("R8 fresh txn first byte", rx[23:16], irq_flags);
        check("R8 fresh txn read", rx[15:8], 8'h0C);

        // R9 bytes past the second
        spi_txn({8'h04, 8'h00, 8'hFF}, 24, rx);
        check("R9 third byte of read", rx[7:0], 8'h00);
        check("R9 second byte of long read", rx[15:8], 8'h0C);
        spi_txn({8'h84, 8'h24, 8'h99}, 24, rx);
        check("R9 third byte not stored", ctrl_o, 8'h24);
        check("R9 third byte of write", rx[7:0], 8'h00);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule